// File: doc/BRIEF.md
# Dual-Channel ADC Conversion Sequencer

This block is the digital control core of a multichannel 10-bit successive-approximation converter. A host processor loads a 10-bit write-only control word over a parallel bus with an active-low chip select and active-low write strobe. The word picks one or two input channels, chooses a single conversion or a paired conversion, and enables three options: reference self-test, power-down, and a status pin that acts either as a busy flag or as an interrupt flag.

When a conversion starts, the block raises a sample-hold strobe and steers the channel multiplexer. It then walks a 10-step binary search against a comparator. The comparator and DAC are modelled as a stub that answers one bit per cycle for the trial code the block presents. In paired mode both channels are held by the same strobe. They are then converted back to back, and each result has its own register. The host collects the results with read strobes on the same bus.

Top module: `dual_adc_seq`

## Requirements
- R1: After reset the control word is zero, `flag_n` is high, `pwr_dn` and `use_ref` are low, `dout_oe` is low and `sar_trial` is zero.
- R2: A rising edge on `wr_n` while `cs_n` is low loads `din` into the control word. If bit 8 of the loaded value is clear, a conversion sequence starts on that same clock edge.
- R3: Bits [2:0] hold the first channel address and bits [5:3] the second. Code k selects input k (0..7), and `chan_sel` carries the address of the conversion in progress. With NUM_CH=4 the top bit of each address is ignored.
- R4: When bit 6 is 0, only the first channel is converted. When bit 6 is 1, `sample_hold` is high for the 2 opening cycles of the first conversion only, and the two channels are converted in order: first address, then second address.
- R5: When bit 7 is 1, `use_ref` is high and the reference level is converted in place of the inputs. Both addresses have no effect, and bit 6 still sets one or two conversions.
- R6: When bit 8 is 1, `pwr_dn` is high and the write starts no conversion, so `flag_n` stays high.
- R7: With bit 9 at 0, `flag_n` is low for exactly 20 cycles for a single conversion and 40 cycles for a pair.
- R8: With bit 9 at 1, `flag_n` stays high for the 20 or 40 conversion cycles and then goes low. It returns high at the next read or write with `cs_n` low.
- R9: Each result is 10-bit two's complement, equal to the comparator threshold code minus 512. The stub answers 1 when the input code is at least the trial code, so input 1023 gives 1FFh, input 0 gives 200h and input 512 gives 000h.
- R10: `dout_oe` is high while `cs_n` and `rd_n` are both low. After a conversion the first read returns the first result. In paired mode successive reads then alternate second, first, and so on. In single mode every read returns the first result.
- R11: A write that arrives while a conversion sequence is running leaves the control word unchanged and does not restart or lengthen the sequence.
- R12: Each conversion spends 2 acquisition cycles and then 10 decision cycles from MSB to LSB. During the first decision cycle `sar_trial` is 200h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; the rising edge loads the control word |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 10 | Control word from the bus |
| dout | output | 10 | Selected result, two's complement |
| dout_oe | output | 1 | Result bus drive enable |
| cmp_bit | input | 1 | Comparator stub answer for the current trial code |
| sar_trial | output | 10 | Trial code presented to the DAC stub |
| chan_sel | output | 3 | Active channel address |
| use_ref | output | 1 | Convert the reference instead of an input |
| sample_hold | output | 1 | Sample-hold strobe for all addressed channels |
| pwr_dn | output | 1 | Power-down request to analog sections |
| flag_n | output | 1 | Shared busy/interrupt status, active low |

## Verification
The bench measures the exact low or high span of `flag_n` in both status modes. A sequencer that padded wrongly, or that dropped the second half of a pair, would show 19, 21 or 20 cycles where 40 are due. Input codes 0, 512 and 1023 exercise the two's complement ends, and a wrong MSB inversion or a wrong comparator polarity would return mirrored codes. A write sent mid-conversion with power-down set must leave `pwr_dn` low and the result intact; a design that accepted it would corrupt the configuration. A third read in paired mode must wrap to the first result, and a pointer that saturated or failed to reset on a new start would return stale data.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
   localparam int CTRL_W = 10;
   localparam int RES_W  = 10;

   typedef struct packed {
      logic       intm;   // status pin as interrupt flag
      logic       pd;     // power-down
      logic       refm;   // reference self-test
      logic       dual;   // paired conversion
      logic [2:0] ch_b;   // second channel address
      logic [2:0] ch_a;   // first channel address
   } ctrl_t;
endpackage

// File: rtl/dseq_bus.sv
module dseq_bus #(
   parameter int CTRL_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [CTRL_W-1:0] din,
   input  logic              busy,
   input  logic              pd_bit_in,
   output logic [CTRL_W-1:0] ctrl,
   output logic              start,
   output logic              rd_done,
   output logic              access
);
   logic wr_q, rd_q, wr_rise, load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b1;
         rd_q <= 1'b1;
      end else begin
         wr_q <= wr_n;
         rd_q <= rd_n;
      end
   end

   assign wr_rise = !cs_n && !wr_q && wr_n;
   assign load    = wr_rise && !busy;
   assign start   = load && !pd_bit_in;
   assign rd_done = !cs_n && !rd_q && rd_n;
   assign access  = !cs_n && (!rd_n || !wr_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctrl <= '0;
      else if (load) ctrl <= din;
   end

   // R11
   ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctrl));
endmodule

// File: rtl/dseq_sar.sv
module dseq_sar #(
   parameter int W        = 10,
   parameter int CONV_CYC = 20,
   parameter int ACQ_CYC  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         dual,
   input  logic         cmp_bit,
   output logic         busy,
   output logic         second,
   output logic         sample_hold,
   output logic [W-1:0] trial,
   output logic [W-1:0] res_a,
   output logic [W-1:0] res_b,
   output logic         done
);
   localparam int CNT_W   = $clog2(CONV_CYC);
   localparam int DEC_END = ACQ_CYC + W;

   if (CONV_CYC < DEC_END) begin : g_bad_len
      $error("CONV_CYC too short for acquisition plus decisions");
   end

   logic [CNT_W-1:0] cnt;
   logic [W-1:0]     partial, bit_sel;
   logic             in_dec, last;

   assign in_dec = busy && (cnt >= CNT_W'(ACQ_CYC)) && (cnt < CNT_W'(DEC_END));
   assign last   = busy && (cnt == CNT_W'(CONV_CYC - 1));

   for (genvar g = 0; g < W; g++) begin : g_bit
      assign bit_sel[g] = in_dec && (cnt == CNT_W'(DEC_END - 1 - g));
   end

   assign trial       = partial | bit_sel;
   assign sample_hold = busy && !second && (cnt < CNT_W'(ACQ_CYC));
   assign done        = last && (second || !dual);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         second  <= 1'b0;
         cnt     <= '0;
         partial <= '0;
         res_a   <= '0;
         res_b   <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         second  <= 1'b0;
         cnt     <= '0;
         partial <= '0;
      end else if (busy) begin
         if (in_dec && cmp_bit) partial <= partial | bit_sel;
         if (last) begin
            if (second) res_b <= {~partial[W-1], partial[W-2:0]};
            else        res_a <= {~partial[W-1], partial[W-2:0]};
            cnt     <= '0;
            partial <= '0;
            if (dual && !second) second <= 1'b1;
            else begin
               busy   <= 1'b0;
               second <= 1'b0;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R12
   sar_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bit_sel));
   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq
   import dseq_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int CONV_CYC = 20,
   parameter int ACQ_CYC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic [CTRL_W-1:0] din,
   output logic [RES_W-1:0] dout,
   output logic             dout_oe,
   input  logic             cmp_bit,
   output logic [RES_W-1:0] sar_trial,
   output logic [2:0]       chan_sel,
   output logic             use_ref,
   output logic             sample_hold,
   output logic             pwr_dn,
   output logic             flag_n
);
   if (NUM_CH != 4 && NUM_CH != 8) begin : g_bad_ch
      $error("NUM_CH must be 4 or 8");
   end

   logic [CTRL_W-1:0] ctrl_raw;
   ctrl_t             c;
   logic              start, rd_done, access;
   logic              busy, second, done;
   logic [RES_W-1:0]  res_a, res_b;
   logic              int_pend, rd_ptr;
   logic [2:0]        addr_raw;

   assign c = ctrl_t'(ctrl_raw);

   dseq_bus #(.CTRL_W(CTRL_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .din(din), .busy(busy), .pd_bit_in(din[8]), .ctrl(ctrl_raw),
      .start(start), .rd_done(rd_done), .access(access)
   );

   dseq_sar #(.W(RES_W), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_sar (
      .clk(clk), .rst_n(rst_n), .start(start), .dual(c.dual),
      .cmp_bit(cmp_bit), .busy(busy), .second(second),
      .sample_hold(sample_hold), .trial(sar_trial),
      .res_a(res_a), .res_b(res_b), .done(done)
   );

   assign addr_raw = second ? c.ch_b : c.ch_a;

   if (NUM_CH == 8) begin : g_addr8
      assign chan_sel = addr_raw;
   end else begin : g_addr4
      assign chan_sel = {1'b0, addr_raw[1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_pend <= 1'b0;
         rd_ptr   <= 1'b0;
      end else begin
         if (start)                 int_pend <= 1'b0;
         else if (done && c.intm)   int_pend <= 1'b1;
         else if (access)           int_pend <= 1'b0;

         if (start)                 rd_ptr <= 1'b0;
         else if (rd_done && c.dual) rd_ptr <= ~rd_ptr;
      end
   end

   assign dout    = rd_ptr ? res_b : res_a;
   assign dout_oe = !cs_n && !rd_n;
   assign flag_n  = c.intm ? !int_pend : !busy;
   assign use_ref = c.refm;
   assign pwr_dn  = c.pd;

   // R6
   pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |-> !busy);
   // R8
   int_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_pend |-> !busy);
   // R4
   second_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      second |-> c.dual);
endmodule

// File: tb/dual_adc_seq_bench.sv
module dual_adc_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [9:0] din = '0;
   logic [9:0] dout, sar_trial;
   logic       dout_oe, cmp_bit, use_ref, sample_hold, pwr_dn, flag_n;
   logic [2:0] chan_sel;
   logic [9:0] vin [8];
   logic [9:0] vref = 10'd530;
   int         total = 0, bad = 0;
   bit         finished = 0;

   always #4 clk = ~clk;

   dual_adc_seq u_dual_adc_seq (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .din(din), .dout(dout), .dout_oe(dout_oe), .cmp_bit(cmp_bit),
      .sar_trial(sar_trial), .chan_sel(chan_sel), .use_ref(use_ref),
      .sample_hold(sample_hold), .pwr_dn(pwr_dn), .flag_n(flag_n)
   );

   // comparator stub: 1 when the held input is at least the trial code
   assign cmp_bit = use_ref ? (vref >= sar_trial) : (vin[chan_sel] >= sar_trial);

   function automatic logic [9:0] expect_code(input logic [9:0] v);
      return 10'(int'(v) - 512);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
      end
   endtask

   task automatic bus_write(input logic [9:0] v);
      @(negedge clk); cs_n = 1'b0; din = v; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
   endtask

   task automatic bus_read(output logic [9:0] v, output logic oe);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk); v = dout; oe = dout_oe; rd_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
   endtask

   // counts negedge samples, starting at the current one, where flag_n == lvl
   task automatic span(input logic lvl, output int n);
      n = 0;
      while (flag_n == lvl && n < 200) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic run_case(input logic [9:0] cw, input string tag);
      int n, want;
      logic [9:0] r, e1, e2;
      logic oe;
      want = cw[6] ? 40 : 20;
      e1 = expect_code(cw[7] ? vref : vin[cw[2:0]]);
      e2 = expect_code(cw[7] ? vref : vin[cw[5:3]]);
      bus_write(cw);
      span(cw[9] ? 1'b1 : 1'b0, n);
      chk(n == want, cw[9] ? "R8 high span" : "R7 low span", n, want);
      if (cw[9]) chk(flag_n == 1'b0, "R8 low after done", flag_n, 0);
      bus_read(r, oe);
      chk(oe == 1'b1, "R10 oe", oe, 1);
      chk(r == e1, {tag, " R9 first result"}, r, e1);
      chk(flag_n == 1'b1, "R8 cleared by read", flag_n, 1);
      if (cw[6]) begin
         bus_read(r, oe);
         chk(r == e2, {tag, " R4 second result"}, r, e2);
      end
   endtask

   initial begin
      logic [9:0] r, cw;
      logic oe;
      int n;
      for (int i = 0; i < 8; i++) vin[i] = 10'(i * 100 + 37);
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(flag_n == 1'b1 && pwr_dn == 1'b0 && use_ref == 1'b0, "R1 flags", {flag_n, pwr_dn, use_ref}, 3'b100);
      chk(dout_oe == 1'b0 && sar_trial == 10'd0, "R1 bus", sar_trial, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 / R4 / R3 timing trace of a single conversion on channel 5
      bus_write(10'h005);
      chk(sample_hold == 1'b1 && chan_sel == 3'd5, "R12 hold cycle0 R3", {sample_hold, chan_sel}, 4'hd);
      @(negedge clk);
      chk(sample_hold == 1'b1 && sar_trial == 10'd0, "R12 hold cycle1", sar_trial, 0);
      @(negedge clk);
      chk(sample_hold == 1'b0 && sar_trial == 10'h200, "R12 MSB trial", sar_trial, 10'h200);
      span(1'b0, n);
      chk(n == 18, "R7 remaining span", n, 18);
      bus_read(r, oe);
      chk(r == expect_code(vin[5]), "R2 R9 ch5", r, expect_code(vin[5]));

      // R9 extremes
      vin[0] = 10'd1023; vin[1] = 10'd0; vin[2] = 10'd512;
      run_case(10'h000, "plus full");
      run_case(10'h001, "minus full");
      run_case(10'h002, "mid");

      // R4 R10 pair, third read wraps to first
      run_case(10'h04A, "pair");
      bus_read(r, oe);
      chk(r == expect_code(vin[2]), "R10 wrap first", r, expect_code(vin[2]));

      // R5 reference pair ignoring addresses
      run_case(10'h0FF, "ref pair");
      chk(use_ref == 1'b1, "R5 use_ref", use_ref, 1);

      // R8 cleared by a write: int mode, then write power-down
      bus_write(10'h213);
      span(1'b1, n);
      chk(n == 20, "R8 span before write", n, 20);
      bus_write(10'h100);
      chk(flag_n == 1'b1 && pwr_dn == 1'b1, "R6 R8 pd write", {flag_n, pwr_dn}, 2'b11);
      repeat (30) @(negedge clk);
      chk(flag_n == 1'b1 && sample_hold == 1'b0, "R6 no conversion", flag_n, 1);

      // R11 write during conversion ignored
      bus_write(10'h003);
      repeat (4) @(negedge clk);
      bus_write(10'h107);
      chk(pwr_dn == 1'b0 && chan_sel == 3'd3, "R11 ctrl kept", {pwr_dn, chan_sel}, 3);
      span(1'b0, n);
      chk(n == 13, "R11 span unchanged", n, 13);
      bus_read(r, oe);
      chk(r == expect_code(vin[3]), "R11 result", r, expect_code(vin[3]));

      // random configurations
      for (int k = 0; k < 30; k++) begin
         for (int j = 0; j < 8; j++) vin[j] = 10'($urandom);
         vref = 10'($urandom);
         cw = 10'($urandom) & 10'h2FF;
         if ($urandom % 3 != 0) cw[7] = 1'b0;
         run_case(cw, "random");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule